// File: doc/BRIEF.md
# Sign-Split Dual PWM Generator

This block turns one signed control word into drive for two opposing actuators: a heating lamp and a cooling fan. The control word is a two's complement number. Its sign picks the channel: a positive value heats and a negative value cools. Its magnitude, divided by a power of two, sets the duty cycle of the chosen channel. The other channel is held low.

Both channels share one free-running period counter. Each channel has its own comparator on that counter. A new control word is captured by a one-cycle load strobe and held as pending. The pending duties replace the active ones only when the counter wraps. A period that is already running therefore always completes with the duty it started with.

Top module: `sign_split_pwm`

## Requirements
- R1: The period counter steps by one every clock from 0 to PERIOD-1, then returns to 0. One PWM period is therefore PERIOD clocks.
- R2: An enabled output is high exactly while the counter value is below that channel's active duty. It rises only when the counter is 0.
- R3: A positive control word gives the lamp output the duty cycle and keeps the fan output low.
- R4: A negative control word gives the fan output the duty cycle and keeps the lamp output low. The two outputs are never high together.
- R5: A control word of zero drives both outputs low for the whole period.
- R6: The duty is the magnitude shifted right by MAG_SHIFT bits, with the fraction dropped. A result above PERIOD is clipped to PERIOD, which holds the output high for the entire period.
- R7: The most negative control word, -2^(CTRL_W-1), gives the largest representable magnitude, 2^(CTRL_W-1)-1. It does not wrap to zero.
- R8: A loaded word takes effect at the first counter wrap after the load. The period in progress is not changed. When several loads arrive in one period, the last one is used.
- R9: During and after reset, the counter, both active duties and both outputs are zero until a loaded word reaches a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | CTRL_W | Signed control word, two's complement |
| ctrl_load_i | input | 1 | Strobe that captures ctrl_i as the pending command |
| lamp_pwm_o | output | 1 | Heating channel PWM output |
| fan_pwm_o | output | 1 | Cooling channel PWM output |

## Verification
A load strobe has no effect on the outputs until the counter next wraps. The new duty shows up in the output register on that same wrap edge, so the first affected sample is counter value 0 of the following period. The bench keeps its own count of clock edges since reset and derives the counter phase and period index from that count. It issues every load at a fixed mid-period phase, and tags the expected duties with the index of the next period. The monitor samples on the falling edge and compares every cycle of every period against the duties in force for that period. This covers both the period that must stay unchanged and the period that must pick up the new value.

// File: rtl/sspwm_pkg.sv
package sspwm_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_HEAT = 2'd1,
    DRV_COOL = 2'd2
  } drive_e;

  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned CH_LAMP  = 0;
  localparam int unsigned CH_FAN   = 1;
endpackage

// File: rtl/sm_split.sv
module sm_split
  import sspwm_pkg::*;
#(
  parameter int unsigned W = 34
) (
  input  logic [W-1:0] val_i,
  output drive_e       dir_o,
  output logic [W-2:0] mag_o
);
  logic [W-1:0] neg_w;
  logic         most_neg;

  assign neg_w    = ~val_i + 1'b1;
  assign most_neg = val_i[W-1] & ~(|val_i[W-2:0]);

  always_comb begin
    dir_o = DRV_OFF;
    mag_o = '0;
    if (val_i == '0) begin
      dir_o = DRV_OFF;
    end else if (!val_i[W-1]) begin
      dir_o = DRV_HEAT;
      mag_o = val_i[W-2:0];
    end else begin
      dir_o = DRV_COOL;
      // saturate instead of wrapping on the most negative code
      mag_o = most_neg ? '1 : neg_w[W-2:0];
    end
  end
endmodule

// File: rtl/duty_scale.sv
module duty_scale #(
  parameter int unsigned MAG_W  = 33,
  parameter int unsigned SHIFT  = 13,
  parameter int unsigned PERIOD = 1000000,
  parameter int unsigned CNT_W  = 20
) (
  input  logic [MAG_W-1:0] mag_i,
  output logic [CNT_W-1:0] duty_o
);
  localparam logic [MAG_W-1:0] LIM = MAG_W'(PERIOD);

  logic [MAG_W-1:0] shifted;

  assign shifted = mag_i >> SHIFT;
  assign duty_o  = (shifted > LIM) ? CNT_W'(PERIOD) : shifted[CNT_W-1:0];
endmodule

// File: rtl/period_ctr.sv
module period_ctr #(
  parameter int unsigned PERIOD = 1000000,
  parameter int unsigned CNT_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o    = (cnt_q == LAST);
  assign cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] duty_nxt_i,
  output logic             pwm_o
);
  // registered so the pin sees no comparator glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 1'b0;
    else         pwm_o <= (cnt_nxt_i < duty_nxt_i);
  end
endmodule

// File: rtl/sign_split_pwm.sv
module sign_split_pwm
  import sspwm_pkg::*;
#(
  parameter int unsigned CTRL_W    = 34,
  parameter int unsigned PERIOD    = 1000000,
  parameter int unsigned MAG_SHIFT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ctrl_load_i,
  output logic              lamp_pwm_o,
  output logic              fan_pwm_o
);
  localparam int unsigned MAG_W = CTRL_W - 1;
  localparam int unsigned CNT_W = $clog2(PERIOD + 1);

  drive_e           dir;
  logic [MAG_W-1:0] mag;
  logic [CNT_W-1:0] duty_raw;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             wrap;

  logic [CNT_W-1:0] pend_q   [NUM_CHAN];
  logic [CNT_W-1:0] duty_q   [NUM_CHAN];
  logic [CNT_W-1:0] duty_nxt [NUM_CHAN];
  logic [NUM_CHAN-1:0] pwm;

  sm_split #(.W(CTRL_W)) i_sm (
    .val_i (ctrl_i),
    .dir_o (dir),
    .mag_o (mag)
  );

  duty_scale #(
    .MAG_W (MAG_W), .SHIFT (MAG_SHIFT), .PERIOD (PERIOD), .CNT_W (CNT_W)
  ) i_scale (
    .mag_i  (mag),
    .duty_o (duty_raw)
  );

  period_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    localparam drive_e SEL = (c == CH_LAMP) ? DRV_HEAT : DRV_COOL;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pend_q[c] <= '0;
      else if (ctrl_load_i) pend_q[c] <= (dir == SEL) ? duty_raw : '0;
    end

    assign duty_nxt[c] = wrap ? pend_q[c] : duty_q[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) duty_q[c] <= '0;
      else         duty_q[c] <= duty_nxt[c];
    end

    pwm_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_nxt_i  (cnt_nxt),
      .duty_nxt_i (duty_nxt[c]),
      .pwm_o      (pwm[c])
    );
  end

  assign lamp_pwm_o = pwm[CH_LAMP];
  assign fan_pwm_o  = pwm[CH_FAN];
endmodule

// File: rtl/sspwm_chk.sv
module sspwm_chk #(
  parameter int unsigned PERIOD = 1000000,
  parameter int unsigned CNT_W  = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] lamp_duty_i,
  input logic [CNT_W-1:0] fan_duty_i,
  input logic             lamp_o,
  input logic             fan_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] MAXD = CNT_W'(PERIOD);

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == LAST) |=> (cnt_i == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != LAST) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1))); // R1
  AST_LAMP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lamp_o) |-> (cnt_i == '0)); // R2
  AST_FAN_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fan_o) |-> (cnt_i == '0)); // R2
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lamp_o && fan_o)); // R4
  AST_ONE_SIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_duty_i == '0) || (fan_duty_i == '0)); // R3
  AST_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_duty_i <= MAXD) && (fan_duty_i <= MAXD)); // R6
  AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != LAST) |=> ($stable(lamp_duty_i) && $stable(fan_duty_i))); // R8
endmodule

bind sign_split_pwm sspwm_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_i       (cnt_q),
  .lamp_duty_i (duty_q[0]),
  .fan_duty_i  (duty_q[1]),
  .lamp_o      (lamp_pwm_o),
  .fan_o       (fan_pwm_o)
);

// File: tb/test_sign_split_pwm.sv
`timescale 1ns/1ps
module test_sign_split_pwm;
  localparam int W  = 34;
  localparam int P  = 20;
  localparam int SH = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] ctrl_i = '0;
  logic         ctrl_load_i = 1'b0;
  logic         lamp_pwm_o, fan_pwm_o;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  bit done   = 0;

  int    q_per[$];
  int    q_lamp[$];
  int    q_fan[$];
  string q_tag[$];

  always #2.5 clk_i = ~clk_i;

  sign_split_pwm #(.CTRL_W(W), .PERIOD(P), .MAG_SHIFT(SH)) i_sign_split_pwm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl_i),
    .ctrl_load_i (ctrl_load_i),
    .lamp_pwm_o  (lamp_pwm_o),
    .fan_pwm_o   (fan_pwm_o)
  );

  always @(posedge clk_i) if (rst_ni) edge_n <= edge_n + 1;

  function automatic int scale(longint m);
    longint s = m >>> SH;
    return (s > P) ? P : int'(s);
  endfunction

  // drive at counter phase ph; expected duties apply from the next period
  task automatic load(longint u, int ph, string tag);
    longint m;
    int el = 0, ef = 0;
    do @(negedge clk_i); while ((edge_n % P) != ph);
    if (u > 0) el = scale(u);
    else if (u < 0) begin
      m  = (u == -(longint'(1) << (W-1))) ? (longint'(1) << (W-1)) - 1 : -u;
      ef = scale(m);
    end
    ctrl_i      = u[W-1:0];
    ctrl_load_i = 1'b1;
    q_per.push_back(edge_n / P + 1);
    q_lamp.push_back(el);
    q_fan.push_back(ef);
    q_tag.push_back(tag);
    @(negedge clk_i);
    ctrl_load_i = 1'b0;
    ctrl_i      = '0;
  endtask

  // monitor: per-sample comparison, one check per period
  initial begin
    int    cur_l = 0, cur_f = 0;
    string cur_t = "R9 reset";
    bit    bad;
    int    al, af, el, ef, bi;
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      if ((edge_n % P) == 0) begin
        while (q_per.size() > 0 && q_per[0] <= edge_n / P) begin
          void'(q_per.pop_front());
          cur_l = q_lamp.pop_front();
          cur_f = q_fan.pop_front();
          cur_t = q_tag.pop_front();
        end
        bad = 0;
      end
      if (!bad && ((lamp_pwm_o !== ((edge_n % P) < cur_l)) ||
                   (fan_pwm_o  !== ((edge_n % P) < cur_f)))) begin
        bad = 1;
        al = lamp_pwm_o; af = fan_pwm_o; bi = edge_n % P;
        el = ((edge_n % P) < cur_l); ef = ((edge_n % P) < cur_f);
      end
      if ((edge_n % P) == P - 1) begin
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s (R2/R8) period %0d cnt %0d: lamp/fan actual %0d/%0d expected %0d/%0d",
                   cur_t, edge_n / P, bi, al, af, el, ef);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (lamp_pwm_o !== 1'b0 || fan_pwm_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 in reset: lamp/fan actual %0b/%0b expected 0/0", lamp_pwm_o, fan_pwm_o);
    end
    rst_ni = 1'b1;
    load(40, 10, "R3 lamp 5");
    load(-64, 10, "R4 fan 8");
    load(0, 10, "R5 zero");
    load(1000, 10, "R6 clip 20");
    load(160, 10, "R6 exact 20");
    load(159, 10, "R6 truncate 19");
    load(-7, 10, "R6 fan rounds to 0");
    load(-(longint'(1) << (W-1)), 10, "R7 most negative");
    load((longint'(1) << (W-1)) - 1, 10, "R3 most positive");
    load(24, 5, "R8 overwritten");
    load(-16, 12, "R8 last load wins");
    load(12, 10, "R3 lamp 1");
    repeat (2 * P + 2) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule